// File: doc/BRIEF.md
# Bus Performance Event Counter Array

This block watches a sampled parallel-bus state (cycle framing, initiator and target ready, stop, device select, request and grant, command and address) together with a small group of external inputs. It keeps a set of event counters. Each counter picks its own event, its own qualifier and its own mode. A prescaled interval timer marks reporting boundaries. At every boundary the whole set of counter values is written, with a running sequence stamp, into an internal two-port FIFO. A host drains that FIFO while counting carries on without a pause.

The address qualifier compares the transaction address against an inclusive programmable window. The address is captured in the cycle in which a transaction starts, so the data phases of that transaction stay qualified even though the address lines carry other values then. A counter can also be gated by an enable that an external sequencer supplies.

Top module: `perf_event_counters`

## Requirements
- R1: There are N_BUS bus counters (default 8) and N_EXT external counters (default 4). Counter i occupies bits [i*CW +: CW] of every snapshot, with the bus counters first. External counter j counts cycles in which ext_in[ext_sel field j] is high.
- R2: Bus counter i takes a 3-bit code from ev_sel[i*3 +: 3]. The codes are: 0 every clock; 1 completed data transfer (irdy_n and trdy_n both low); 2 bus busy (frame_n low or irdy_n low); 3 transaction start; 4 target retry (stop_n low, trdy_n high, devsel_n low); 5 req_n low; 6 gnt_n low; 7 transaction start with cmd 4'h6 or 4'h7.
- R3: Counter i takes a qualifier code from qual_sel[i*2 +: 2]. The codes are: 0 every cycle; 1 address window; 2 seq_en high; 3 never. An event is counted only when its qualifier is true in the same cycle.
- R4: A transaction starts in a cycle where frame_n is low and was high in the previous sampled cycle (high after reset). The address qualifier is true when win_lo <= addr <= win_hi, both ends included. It is evaluated on addr in the start cycle and then held for every cycle until the next start.
- R5: The timer ticks once every max(prescale,1) clocks. A boundary falls on every max(interval,1)-th tick. The first tick after reset comes on the prescale-th clock edge.
- R6: A snapshot contains the event counted in the boundary cycle itself. After a boundary, a counter with acc_mode[i]=0 restarts from zero. A counter with acc_mode[i]=1 keeps its value.
- R7: Each FIFO entry carries a sequence stamp. The stamp is 0 for the first boundary after reset and rises by one at every boundary, whether or not the entry is stored.
- R8: A boundary that finds the FIFO full stores nothing and sets overflow. Overflow stays set until reset.
- R9: A counter at its all-ones value holds that value and does not wrap.
- R10: The FIFO is show-ahead. While fifo_empty is low, rd_seq and rd_counts present the oldest entry, and rd_en pops it at the clock edge. Entries come out in boundary order, and reading never stops counting.
- R11: After reset the FIFO is empty, overflow is low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| devsel_n | input | 1 | Device selected, active low |
| req_n | input | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| cmd | input | 4 | Bus command |
| addr | input | AW | Address lines |
| ext_in | input | EXT_IN | External signal inputs |
| seq_en | input | 1 | Sequencer enable qualifier |
| ev_sel | input | N_BUS*3 | Bus event codes |
| ext_sel | input | N_EXT*clog2(EXT_IN) | External input index per external counter |
| qual_sel | input | (N_BUS+N_EXT)*2 | Qualifier code per counter |
| acc_mode | input | N_BUS+N_EXT | 1 = accumulate, 0 = reset at boundary |
| win_lo | input | AW | Address window low bound |
| win_hi | input | AW | Address window high bound |
| prescale | input | PW | Clocks per timer tick |
| interval | input | 32 | Ticks per reporting interval |
| rd_en | input | 1 | Pop the oldest entry |
| fifo_empty | output | 1 | No entry available |
| rd_seq | output | SW | Sequence stamp of the oldest entry |
| rd_counts | output | (N_BUS+N_EXT)*CW | Counter values of the oldest entry |
| overflow | output | 1 | Sticky: a snapshot was dropped |

## Verification
The bench builds the block with CW=8, SW=8, AW=16 and DEPTH=2, and keeps the defaults for the counter counts. With 8-bit counters, an accumulating clock counter reaches saturation within a few hundred cycles. With a two-entry FIFO, a stopped host causes dropped snapshots after only two boundaries, so the stamp gap and the sticky flag can be seen. The 16-bit address makes it cheap to drive transactions exactly at both window edges and one past them.

// File: rtl/perf_event_counters.sv
module perf_event_counters #(
  parameter int N_BUS  = 8,
  parameter int N_EXT  = 4,
  parameter int EXT_IN = 4,
  parameter int CW     = 32,
  parameter int AW     = 32,
  parameter int PW     = 16,
  parameter int SW     = 16,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_n,
  input  logic                          irdy_n,
  input  logic                          trdy_n,
  input  logic                          stop_n,
  input  logic                          devsel_n,
  input  logic                          req_n,
  input  logic                          gnt_n,
  input  logic [3:0]                    cmd,
  input  logic [AW-1:0]                 addr,
  input  logic [EXT_IN-1:0]             ext_in,
  input  logic                          seq_en,
  input  logic [N_BUS*3-1:0]            ev_sel,
  input  logic [N_EXT*$clog2(EXT_IN)-1:0] ext_sel,
  input  logic [(N_BUS+N_EXT)*2-1:0]    qual_sel,
  input  logic [N_BUS+N_EXT-1:0]        acc_mode,
  input  logic [AW-1:0]                 win_lo,
  input  logic [AW-1:0]                 win_hi,
  input  logic [PW-1:0]                 prescale,
  input  logic [31:0]                   interval,
  input  logic                          rd_en,
  output logic                          fifo_empty,
  output logic [SW-1:0]                 rd_seq,
  output logic [(N_BUS+N_EXT)*CW-1:0]   rd_counts,
  output logic                          overflow
);
  localparam int NC = N_BUS + N_EXT;
  localparam int XW = $clog2(EXT_IN);
  localparam int DW = $clog2(DEPTH);
  localparam int EW = SW + NC*CW;

  logic          prev_frame_n, win_held, start, win_now, in_win;
  logic [7:0]    bus_ev;
  logic [PW-1:0] pre_cnt;
  logic [31:0]   tick_cnt;
  logic          tick, boundary;
  logic [CW-1:0] cnt [NC];
  logic [CW-1:0] nxt [NC];
  logic [NC*CW-1:0] snap;
  logic [EW-1:0] mem [DEPTH];
  logic [DW-1:0] wp, rp;
  logic [DW:0]   fcnt;
  logic [SW-1:0] seq;
  logic          full, wr, rd;

  assign start   = prev_frame_n & ~frame_n;
  assign win_now = (addr >= win_lo) && (addr <= win_hi);
  assign in_win  = start ? win_now : win_held;

  assign bus_ev[0] = 1'b1;
  assign bus_ev[1] = ~irdy_n & ~trdy_n;
  assign bus_ev[2] = ~frame_n | ~irdy_n;
  assign bus_ev[3] = start;
  assign bus_ev[4] = ~stop_n & trdy_n & ~devsel_n;
  assign bus_ev[5] = ~req_n;
  assign bus_ev[6] = ~gnt_n;
  assign bus_ev[7] = start & ((cmd == 4'h6) | (cmd == 4'h7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_frame_n <= 1'b1;
      win_held     <= 1'b0;
    end else begin
      prev_frame_n <= frame_n;
      if (start) win_held <= win_now;
    end
  end

  assign tick     = ({1'b0, pre_cnt} + (PW+1)'(1)) >= {1'b0, prescale};
  assign boundary = tick && (({1'b0, tick_cnt} + 33'd1) >= {1'b0, interval});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
      if (tick) tick_cnt <= boundary ? '0 : tick_cnt + 32'd1;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_ctr
    logic ev, qual;
    if (i < N_BUS) begin : g_bus
      assign ev = bus_ev[ev_sel[i*3 +: 3]];
    end else begin : g_ext
      assign ev = ext_in[ext_sel[(i-N_BUS)*XW +: XW]];
    end
    always_comb begin
      case (qual_sel[i*2 +: 2])
        2'd0:    qual = 1'b1;
        2'd1:    qual = in_win;
        2'd2:    qual = seq_en;
        default: qual = 1'b0;
      endcase
    end
    assign nxt[i] = (ev && qual && (cnt[i] != {CW{1'b1}})) ? cnt[i] + CW'(1) : cnt[i];
    assign snap[i*CW +: CW] = nxt[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt[i] <= '0;
      else if (boundary && !acc_mode[i]) cnt[i] <= '0;
      else                               cnt[i] <= nxt[i];
    end
  end

  assign full       = fcnt == (DW+1)'(DEPTH);
  assign fifo_empty = fcnt == '0;
  assign wr         = boundary && !full;
  assign rd         = rd_en && !fifo_empty;
  assign {rd_seq, rd_counts} = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {seq, snap};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      fcnt     <= '0;
      seq      <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr) wp <= wp + DW'(1);
      if (rd) rp <= rp + DW'(1);
      case ({wr, rd})
        2'b10:   fcnt <= fcnt + (DW+1)'(1);
        2'b01:   fcnt <= fcnt - (DW+1)'(1);
        default: fcnt <= fcnt;
      endcase
      if (boundary) seq <= seq + SW'(1);
      if (boundary && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/perf_event_counters_chk.sv
module perf_event_counters_chk #(
  parameter int CW    = 32,
  parameter int SW    = 16,
  parameter int DEPTH = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     boundary,
  input logic                     full,
  input logic                     rd_en,
  input logic                     overflow,
  input logic [SW-1:0]            seq,
  input logic [CW-1:0]            cnt0,
  input logic                     acc0,
  input logic [$clog2(DEPTH):0]   fcount
);
  a_r5_boundary_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> tick);

  a_r7_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> seq == $past(seq) + SW'(1));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && full) |=> overflow);

  a_r9_saturate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == {CW{1'b1}} && acc0) |=> cnt0 == {CW{1'b1}});

  a_r10_full_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcount <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind perf_event_counters perf_event_counters_chk #(.CW(CW), .SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .boundary(boundary), .full(full),
  .rd_en(rd_en), .overflow(overflow), .seq(seq), .cnt0(cnt[0]),
  .acc0(acc_mode[0]), .fcount(fcnt)
);

// File: tb/perf_event_counters_test.sv
`timescale 1ns/1ps
module perf_event_counters_test;
  localparam int CW = 8, SW = 8, AW = 16, PW = 4, DEPTH = 2, NC = 12;
  localparam int EWB = SW + NC*CW;

  logic clk = 0, rst_n = 0;
  logic frame_n = 1, irdy_n = 1, trdy_n = 1, stop_n = 1, devsel_n = 1, req_n = 1, gnt_n = 1;
  logic [3:0] cmd = 0;
  logic [AW-1:0] addr = 0;
  logic [3:0] ext_in = 0;
  logic seq_en = 0;
  logic [23:0] ev_sel = 0;
  logic [7:0] ext_sel = 0;
  logic [23:0] qual_sel = 0;
  logic [11:0] acc_mode = 0;
  logic [AW-1:0] win_lo = 16'h1000, win_hi = 16'h1FFF;
  logic [PW-1:0] prescale = 2;
  logic [31:0] interval = 20;
  logic rd_en = 0;
  logic fifo_empty, overflow;
  logic [SW-1:0] rd_seq;
  logic [NC*CW-1:0] rd_counts;

  perf_event_counters #(.N_BUS(8), .N_EXT(4), .EXT_IN(4), .CW(CW), .AW(AW), .PW(PW),
                        .SW(SW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .devsel_n(devsel_n), .req_n(req_n), .gnt_n(gnt_n), .cmd(cmd),
    .addr(addr), .ext_in(ext_in), .seq_en(seq_en), .ev_sel(ev_sel), .ext_sel(ext_sel),
    .qual_sel(qual_sel), .acc_mode(acc_mode), .win_lo(win_lo), .win_hi(win_hi),
    .prescale(prescale), .interval(interval), .rd_en(rd_en), .fifo_empty(fifo_empty),
    .rd_seq(rd_seq), .rd_counts(rd_counts), .overflow(overflow));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit drain = 0;
  int exp_period = 40;
  logic [EWB-1:0] sb [$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, written from the requirements
  int m_pre, m_tk, m_seq, m_occ;
  int m_cnt [NC];
  bit m_prevf, m_winq, m_st, m_w, m_tick, m_bnd, m_q, m_ev, m_full;
  logic [EWB-1:0] m_e;

  function automatic bit ev_of(int i, bit st);
    if (i < 8) begin
      case (ev_sel[i*3 +: 3])
        3'd0: return 1'b1;
        3'd1: return !irdy_n && !trdy_n;
        3'd2: return !frame_n || !irdy_n;
        3'd3: return st;
        3'd4: return !stop_n && trdy_n && !devsel_n;
        3'd5: return !req_n;
        3'd6: return !gnt_n;
        default: return st && (cmd == 4'h6 || cmd == 4'h7);
      endcase
    end
    return ext_in[ext_sel[(i-8)*2 +: 2]];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_tk = 0; m_seq = 0; m_occ = 0; m_prevf = 1; m_winq = 0;
      for (int i = 0; i < NC; i++) m_cnt[i] = 0;
      sb.delete();
    end else begin
      m_st = m_prevf && !frame_n;
      m_prevf = frame_n;
      m_w = m_st ? (addr >= win_lo && addr <= win_hi) : m_winq;
      if (m_st) m_winq = m_w;
      m_tick = (m_pre + 1) >= ((prescale == 0) ? 1 : int'(prescale));
      m_pre = m_tick ? 0 : m_pre + 1;
      m_bnd = 0;
      if (m_tick) begin
        if (m_tk + 1 >= ((interval == 0) ? 1 : int'(interval))) begin m_bnd = 1; m_tk = 0; end
        else m_tk++;
      end
      for (int i = 0; i < NC; i++) begin
        m_ev = ev_of(i, m_st);
        case (qual_sel[i*2 +: 2])
          2'd0: m_q = 1; 2'd1: m_q = m_w; 2'd2: m_q = seq_en; default: m_q = 0;
        endcase
        if (m_ev && m_q && m_cnt[i] < 255) m_cnt[i]++;
      end
      m_full = (m_occ == DEPTH);
      if (m_bnd) begin
        m_e[EWB-1 -: SW] = SW'(m_seq);
        for (int i = 0; i < NC; i++) m_e[i*CW +: CW] = CW'(m_cnt[i]);
        if (!m_full) begin sb.push_back(m_e); m_occ++; end
        m_seq++;
        for (int i = 0; i < NC; i++) if (!acc_mode[i]) m_cnt[i] = 0;
      end
      if (rd_en && m_occ > 0) m_occ--;
    end
  end

  // monitor: pops expected entries as the design presents them
  logic [EWB-1:0] got;
  always @(negedge clk) begin
    rd_en = 0;
    if (rst_n && drain && !fifo_empty) begin
      if (sb.size() == 0) chk("R10 unexpected entry", 1, 0);
      else begin
        got = sb.pop_front();
        chk("R7 R8 R10 sequence stamp", int'(rd_seq), int'(got[EWB-1 -: SW]));
        for (int i = 0; i < NC; i++) begin
          if (i < 8) chk($sformatf("R1 R2 R3 R4 R6 bus counter %0d", i),
                         int'(rd_counts[i*CW +: CW]), int'(got[i*CW +: CW]));
          else chk($sformatf("R1 R3 R6 ext counter %0d", i),
                   int'(rd_counts[i*CW +: CW]), int'(got[i*CW +: CW]));
        end
        if (got[CW-1:0] == 8'hFF) chk("R9 saturation", int'(rd_counts[CW-1:0]), 255);
        if (got[EWB-1 -: SW] == 0 && exp_period > 0)
          chk("R5 first interval length", int'(rd_counts[CW-1:0]), exp_period);
        rd_en = 1;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  task automatic side();
    ext_in = 4'($urandom); seq_en = 1'($urandom);
    req_n = 1'($urandom); gnt_n = 1'($urandom);
  endtask

  task automatic idle();
    @(negedge clk);
    frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1; devsel_n = 1; side();
  endtask

  task automatic txn(logic [AW-1:0] a, logic [3:0] c, int nd, bit retry);
    @(negedge clk);
    frame_n = 0; addr = a; cmd = c; irdy_n = 1; trdy_n = 1; side();
    if (retry) begin
      @(negedge clk);
      addr = AW'($urandom); frame_n = 1; irdy_n = 0; devsel_n = 0; stop_n = 0; side();
    end else begin
      for (int k = 0; k < nd; k++) begin
        @(negedge clk);
        addr = AW'($urandom); irdy_n = 0; devsel_n = 0;
        trdy_n = (($urandom % 3) == 0); frame_n = (k == nd-1); side();
      end
    end
    idle();
  endtask

  task automatic traffic(int n);
    int t0 = cyc;
    logic [AW-1:0] picks [6] = '{16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h1800, 16'h4000};
    logic [3:0] cmds [4] = '{4'h6, 4'h7, 4'h2, 4'hC};
    while (cyc - t0 < n) begin
      txn(picks[$urandom % 6], cmds[$urandom % 4], 1 + ($urandom % 4), ($urandom % 5) == 0);
      if ($urandom % 2) idle();
    end
  endtask

  task automatic set_ctr(int i, int ev, int q, bit acc);
    if (i < 8) ev_sel[i*3 +: 3] = 3'(ev); else ext_sel[(i-8)*2 +: 2] = 2'(ev);
    qual_sel[i*2 +: 2] = 2'(q);
    acc_mode[i] = acc;
  endtask

  task automatic restart();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk); drain = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 empty after reset", int'(fifo_empty), 1);
    chk("R11 overflow clear after reset", int'(overflow), 0);
  endtask

  initial begin
    set_ctr(0, 0, 0, 0); set_ctr(1, 1, 0, 0); set_ctr(2, 1, 1, 0); set_ctr(3, 1, 2, 0);
    set_ctr(4, 3, 0, 1); set_ctr(5, 4, 0, 0); set_ctr(6, 5, 3, 0); set_ctr(7, 7, 1, 1);
    set_ctr(8, 0, 0, 0); set_ctr(9, 1, 2, 0); set_ctr(10, 2, 0, 1); set_ctr(11, 3, 1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 empty after reset", int'(fifo_empty), 1);
    chk("R11 overflow clear after reset", int'(overflow), 0);
    chk("R11 no data before first boundary", int'(fifo_empty), 1);

    // phase 1: mixed events, qualifiers and modes, 40-clock interval
    drain = 1;
    traffic(230);

    // phase 2: accumulating clock counter runs into saturation
    restart();
    set_ctr(0, 0, 0, 1);
    drain = 1;
    traffic(420);

    // phase 3: host stops reading, 7-clock interval, snapshots are dropped
    prescale = 0; interval = 7; exp_period = 0; set_ctr(0, 0, 0, 0);
    restart();
    exp_period = 7;
    repeat (30) idle();
    chk("R8 overflow after dropped snapshot", int'(overflow), 1);
    chk("R10 entries held while not read", int'(fifo_empty), 0);
    chk("R10 oldest entry stamp", int'(rd_seq), 0);
    drain = 1;
    traffic(40);
    chk("R8 overflow stays set", int'(overflow), 1);
    restart();
    drain = 1;
    repeat (20) idle();
    while (sb.size() != 0) @(negedge clk);
    chk("R10 all expected entries read", sb.size(), 0);
    finish_run();
  end
endmodule